// File: doc/BRIEF.md
# Push-Button Short/Long Press Classifier

This block watches an active-low push button in the system clock domain and sorts each valid press into one of two kinds. The button is first brought through a two-stage sampling register, and a falling edge of the sampled level opens an event, but only while the `busy_in` input is low. A prescaler then produces a sample tick every `SAMPLE_US` microseconds. Three ticks must all see the button held before the press counts as real. If any of them sees it released, the event is dropped with no action.

After confirmation the block keeps sampling on each tick. If the button is seen released before the long-press limit (`LONG_US`), the press is short, and the upload/download direction bit flips. If it is still held when the limit runs out, the press is long: the block emits a one-cycle start pulse and tags it with the current direction. Whichever the outcome, the block then waits for `RELEASE_SAMPLES` released samples in a row, starting the count again on any pressed sample, and only after that does it re-arm. The action that a long press begins lies outside this block.

Top module: `btn_press_classifier`

## Requirements
- R1: An event opens only on a falling edge of the sampled button (high then low in the two-stage register) seen while `busy_in` is 0; an edge seen while `busy_in` is 1 causes no busy, no toggle and no pulse.
- R2: A press is confirmed only if `CONFIRM_SAMPLES` consecutive ticks (3 by default) all see it held; a released sample during confirmation ends the event with `busy_out` back to 0 and both `dir_upload` and `start_pulse` unchanged.
- R3: Sample ticks fall every TICK_DIV = CLK_HZ/1e6*SAMPLE_US clocks, with the prescaler restarted on the cycle an event opens, so the first tick comes TICK_DIV clocks after that cycle.
- R4: A confirmed press seen released on a tick before the long limit is short: `dir_upload` inverts (1 = upload, 0 = download).
- R5: A confirmed press still held on the LONG_US/SAMPLE_US-th tick after confirmation is long: `start_pulse` is high for exactly one cycle, `start_dir` takes the value `dir_upload` had then, and `dir_upload` is unchanged.
- R6: After either outcome the block re-arms only after `RELEASE_SAMPLES` consecutive released ticks (10 by default); any pressed tick restarts the count from zero.
- R7: `busy_out` is 1 from the clock after the opening edge until the release wait completes; falling edges during that time open no new event.
- R8: After synchronous reset `dir_upload` is 0 (download), `start_pulse` is 0, `start_dir` is 0, `busy_out` is 0, and the sampled button level reads released.
- R9: `start_dir` changes only on a cycle where `start_pulse` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_n | input | 1 | Push button, 0 = pressed |
| busy_in | input | 1 | When 1, new presses are not detected |
| busy_out | output | 1 | High while an event is in progress |
| dir_upload | output | 1 | Direction bit, 1 = upload, 0 = download |
| start_pulse | output | 1 | One-cycle pulse on a long press |
| start_dir | output | 1 | Direction captured with the last start pulse |

## Verification
On every cycle the assertions check these rules: the start pulse lasts one cycle, the pulse and any direction flip happen only while busy is high, `start_dir` moves only with a pulse, and busy only rises after a cycle in which `busy_in` was low. The rest can only be shown by the bench's scenarios: how long the confirmation, long-press and release windows last, the tick spacing, the abandoning of glitches, and the restart of the release count on a bounce. A behavioural model in the bench follows these and is compared with every output on each clock.

// File: rtl/btnc_pkg.sv
package btnc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_HOLD    = 2'd2,
        ST_RELEASE = 2'd3
    } btnc_state_t;

    typedef struct packed {
        logic pulse;
        logic dir;
    } btnc_start_t;

    function automatic int btnc_max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int btnc_width(input int maxval);
        return (maxval < 2) ? 1 : $clog2(maxval + 1);
    endfunction

endpackage

// File: rtl/btnc_tick.sv
module btnc_tick #(
    parameter int TICK_DIV = 1250000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    import btnc_pkg::*;

    localparam int W = btnc_width(TICK_DIV);
    localparam logic [W-1:0] LAST = W'(TICK_DIV - 1);

    logic [W-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/btnc_sync.sv
module btnc_sync (
    input  logic clk,
    input  logic rst,
    input  logic btn_n,
    output logic released,
    output logic fall
);
    logic stage1, stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= 1'b1;
            stage2 <= 1'b1;
        end else begin
            stage1 <= btn_n;
            stage2 <= stage1;
        end
    end

    assign released = stage1;
    assign fall     = stage2 & ~stage1;
endmodule

// File: rtl/btnc_fsm.sv
module btnc_fsm #(
    parameter int CONFIRM_SAMPLES = 3,
    parameter int LONG_TICKS      = 140,
    parameter int RELEASE_SAMPLES = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic fall,
    input  logic released,
    input  logic tick,
    input  logic busy_in,
    output logic arm,
    output logic busy_out,
    output logic dir_upload,
    output btnc_pkg::btnc_start_t start
);
    import btnc_pkg::*;

    localparam int CMAX = btnc_max3(CONFIRM_SAMPLES, LONG_TICKS, RELEASE_SAMPLES);
    localparam int CW   = btnc_width(CMAX);
    localparam logic [CW-1:0] CONF_LAST = CW'(CONFIRM_SAMPLES - 1);
    localparam logic [CW-1:0] LONG_LAST = CW'(LONG_TICKS - 1);
    localparam logic [CW-1:0] REL_LAST  = CW'(RELEASE_SAMPLES - 1);

    btnc_state_t state;
    logic [CW-1:0] cnt;
    logic dir_q;

    assign arm        = (state == ST_IDLE) && fall && !busy_in;
    assign busy_out   = (state != ST_IDLE);
    assign dir_upload = dir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            dir_q <= 1'b0;
            start <= '0;
        end else begin
            start.pulse <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (arm) begin
                        state <= ST_CONFIRM;
                        cnt   <= '0;
                    end
                end
                ST_CONFIRM: begin
                    if (tick) begin
                        if (released) begin
                            state <= ST_IDLE;
                        end else if (cnt == CONF_LAST) begin
                            state <= ST_HOLD;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_HOLD: begin
                    if (tick) begin
                        if (released) begin
                            dir_q <= ~dir_q;
                            state <= ST_RELEASE;
                            cnt   <= '0;
                        end else if (cnt == LONG_LAST) begin
                            start.pulse <= 1'b1;
                            start.dir   <= dir_q;
                            state       <= ST_RELEASE;
                            cnt         <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    if (tick) begin
                        if (!released)
                            cnt <= '0;
                        else if (cnt == REL_LAST)
                            state <= ST_IDLE;
                        else
                            cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/btn_press_classifier.sv
module btn_press_classifier #(
    parameter int CLK_HZ          = 250000000,
    parameter int SAMPLE_US       = 5000,
    parameter int LONG_US         = 700000,
    parameter int CONFIRM_SAMPLES = 3,
    parameter int RELEASE_SAMPLES = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_n,
    input  logic busy_in,
    output logic busy_out,
    output logic dir_upload,
    output logic start_pulse,
    output logic start_dir
);
    import btnc_pkg::*;

    localparam int TICK_DIV   = (CLK_HZ / 1000000) * SAMPLE_US;
    localparam int LONG_TICKS = LONG_US / SAMPLE_US;

    logic released, fall, tick, arm;
    btnc_start_t start;

    btnc_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .btn_n    (btn_n),
        .released (released),
        .fall     (fall)
    );

    btnc_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .restart (arm),
        .tick    (tick)
    );

    btnc_fsm #(
        .CONFIRM_SAMPLES (CONFIRM_SAMPLES),
        .LONG_TICKS      (LONG_TICKS),
        .RELEASE_SAMPLES (RELEASE_SAMPLES)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .fall       (fall),
        .released   (released),
        .tick       (tick),
        .busy_in    (busy_in),
        .arm        (arm),
        .busy_out   (busy_out),
        .dir_upload (dir_upload),
        .start      (start)
    );

    assign start_pulse = start.pulse;
    assign start_dir   = start.dir;
endmodule

// File: rtl/btnc_checker.sv
module btnc_checker (
    input logic clk,
    input logic rst,
    input logic busy_in,
    input logic busy_out,
    input logic dir_upload,
    input logic start_pulse,
    input logic start_dir
);
    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse);

    assert_pulse_in_event_R7: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> busy_out);

    assert_dir_in_event_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(dir_upload) |-> busy_out);

    assert_sdir_with_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(start_dir) |-> start_pulse);

    assert_open_not_busy_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_out) |-> !$past(busy_in));

    assert_dir_held_on_long_R5: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> (start_dir == dir_upload));
endmodule

bind btn_press_classifier btnc_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy_in     (busy_in),
    .busy_out    (busy_out),
    .dir_upload  (dir_upload),
    .start_pulse (start_pulse),
    .start_dir   (start_dir)
);

// File: tb/btn_press_classifier_test.sv
module btn_press_classifier_test;
    localparam int TD  = 4;
    localparam int LNG = 8;
    localparam int CNF = 3;
    localparam int REL = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic btn_n = 1'b1;
    logic busy_in = 1'b0;
    logic busy_out, dir_upload, start_pulse, start_dir;

    int checks = 0;
    int failures = 0;
    int pulses = 0;
    bit done = 0;

    always #2 clk = ~clk;

    btn_press_classifier #(
        .CLK_HZ(1000000), .SAMPLE_US(TD), .LONG_US(TD*LNG),
        .CONFIRM_SAMPLES(CNF), .RELEASE_SAMPLES(REL)
    ) uut (
        .clk(clk), .rst(rst), .btn_n(btn_n), .busy_in(busy_in),
        .busy_out(busy_out), .dir_upload(dir_upload),
        .start_pulse(start_pulse), .start_dir(start_dir)
    );

    // behavioural reference model
    int m_phase, m_cnt, m_el;
    bit m_s1, m_s2, m_dir, m_pulse, m_sdir;
    always @(posedge clk) begin
        bit fl, rl, tk;
        if (rst) begin
            m_phase = 0; m_cnt = 0; m_el = 0;
            m_s1 = 1; m_s2 = 1; m_dir = 0; m_pulse = 0; m_sdir = 0;
        end else begin
            fl = m_s2 && !m_s1;
            rl = m_s1;
            m_el++;
            tk = (m_el % TD) == 0;
            m_pulse = 0;
            case (m_phase)
                0: if (fl && !busy_in) begin m_phase = 1; m_cnt = 0; m_el = 0; end
                1: if (tk) begin
                       if (rl) m_phase = 0;
                       else begin m_cnt++; if (m_cnt == CNF) begin m_phase = 2; m_cnt = 0; end end
                   end
                2: if (tk) begin
                       if (rl) begin m_dir = !m_dir; m_phase = 3; m_cnt = 0; end
                       else begin
                           m_cnt++;
                           if (m_cnt == LNG) begin m_pulse = 1; m_sdir = m_dir; m_phase = 3; m_cnt = 0; end
                       end
                   end
                default: if (tk) begin
                       if (!rl) m_cnt = 0;
                       else begin m_cnt++; if (m_cnt == REL) m_phase = 0; end
                   end
            endcase
            m_s2 = m_s1;
            m_s1 = btn_n;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R7 busy_out", busy_out, m_phase != 0);
            chk("R4 dir_upload", dir_upload, m_dir);
            chk("R5 start_pulse", start_pulse, m_pulse);
            chk("R9 start_dir", start_dir, m_sdir);
            if (start_pulse) pulses++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R8 reset state
        chk("R8 busy", busy_out, 1'b0);
        chk("R8 dir", dir_upload, 1'b0);
        chk("R8 pulse", start_pulse, 1'b0);

        // R2 glitch abandoned
        btn_n = 0; cyc(10); btn_n = 1; cyc(30);
        chk("R2 glitch busy", busy_out, 1'b0);
        chk("R2 glitch dir", dir_upload, 1'b0);
        chk("R2 glitch pulses", pulses != 0, 1'b0);

        // R3 busy rises two clocks after press, first tick TD later
        btn_n = 0; cyc(1);
        chk("R3 no busy yet", busy_out, 1'b0);
        cyc(1);
        chk("R3 busy opened", busy_out, 1'b1);
        cyc(23); btn_n = 1; cyc(10);
        // R4 short press
        chk("R4 short toggled", dir_upload, 1'b1);
        chk("R7 busy in release wait", busy_out, 1'b1);
        cyc(60);
        chk("R6 re-armed", busy_out, 1'b0);

        // R1 busy_in blocks detection
        busy_in = 1; btn_n = 0; cyc(30); busy_in = 0; cyc(60); btn_n = 1; cyc(20);
        chk("R1 blocked busy", busy_out, 1'b0);
        chk("R1 blocked dir", dir_upload, 1'b1);

        // R5 long press with bounce in release wait (R6)
        btn_n = 0; cyc(80);
        chk("R5 one pulse", pulses == 1, 1'b1);
        chk("R5 start_dir upload", start_dir, 1'b1);
        chk("R5 dir kept", dir_upload, 1'b1);
        btn_n = 1; cyc(12); btn_n = 0; cyc(6); btn_n = 1; cyc(30);
        chk("R6 restart after bounce", busy_out, 1'b1);
        // R7 edge during release wait ignored
        btn_n = 0; cyc(3); btn_n = 1; cyc(80);
        chk("R7 no new event", busy_out, 1'b0);
        chk("R7 dir kept", dir_upload, 1'b1);

        // R4 second short toggles back to download
        btn_n = 0; cyc(25); btn_n = 1; cyc(70);
        chk("R4 back to download", dir_upload, 1'b0);
        chk("R5 pulse total", pulses == 1, 1'b1);

        // R5 long press in download direction
        btn_n = 0; cyc(70); btn_n = 1; cyc(70);
        chk("R5 second pulse", pulses == 2, 1'b1);
        chk("R5 start_dir download", start_dir, 1'b0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule